// File: doc/BRIEF.md
# Bus-to-NoC Request Adaptor

This block sits between a memory-mapped bus slave port and the local port of a network-on-chip router. Each accepted bus read or write becomes one 77-bit request flit. The flit is marked as both the head and the tail of its packet. It carries the processor number, the destination memory coordinates and the access itself, and it leaves on the router port in the cycle after acceptance. Reads and writes share a single channel, so the path through the mesh is fixed.

Transmission is gated by a credit counter that mirrors the free space in the router's input buffer. The block holds the master with `bus_waitreq` in three cases: no credit is left, the limit of outstanding reads has been reached, or a write is still being handed over. Reads may follow one another on consecutive cycles. A write stalls the bus for one cycle and needs no acknowledgement.

Response flits from the router are queued in a small FIFO. They are returned to the master as read data, in arrival order, each with a one-cycle valid pulse. A response that finds the FIFO full is dropped and latches a sticky error flag.

Top module: `noc_bus_adaptor`

## Requirements
- R1: A request flit is laid out from bit 76 down as follows:
  - service level (1 bit, parameter `SVC_LEVEL`)
  - packet type (2 bits, request = 2'b01)
  - processor number (2 bits, parameter `PROC_ID`)
  - access kind (1 bit, write = 1, read = 0)
  - write data (32 bits, zero for a read)
  - bus address (31 bits)
  - memory X (4 bits, `MEM_X`)
  - memory Y (4 bits, `MEM_Y`)
- R2: A request is accepted at a rising edge where `bus_read` or `bus_write` is high and `bus_waitreq` is low. Each acceptance produces exactly one flit: `tx_valid` is high for one cycle right after that edge, and never otherwise.
- R3: After a write is accepted, `bus_waitreq` is high for the following cycle. Reads can be accepted on every consecutive cycle while the other limits allow it.
- R4: The credit count starts at `CREDITS`. It drops by one at each acceptance and rises by one for each cycle with `credit_ret` high. While it is zero, `bus_waitreq` is high and nothing is sent.
- R5: While `MAX_OUT` reads are accepted but not yet returned on `bus_readvalid`, `bus_waitreq` is high. It drops in the cycle in which a read is returned.
- R6: A response flit taken at edge F produces `bus_readvalid` high for exactly one cycle after edge F+1. `bus_readdata` then equals flit bits 70:39. Responses are returned in arrival order.
- R7: A response flit that arrives while the FIFO already holds `FIFO_DEPTH` entries at the start of the cycle is discarded. It sets `err_overflow`, which stays high until reset.
- R8: After reset, `bus_waitreq`, `tx_valid`, `bus_readvalid` and `err_overflow` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | single clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_read | input | 1 | read request |
| bus_write | input | 1 | write request |
| bus_addr | input | 31 | access address |
| bus_wdata | input | 32 | write data |
| bus_waitreq | output | 1 | stall the master |
| bus_readvalid | output | 1 | read data valid, one cycle per response |
| bus_readdata | output | 32 | returned read data |
| tx_valid | output | 1 | request flit valid toward router |
| tx_flit | output | 77 | request flit |
| credit_ret | input | 1 | one buffer slot freed in the router |
| rx_valid | input | 1 | response flit valid from router |
| rx_flit | input | 77 | response flit |
| err_overflow | output | 1 | sticky response-FIFO overflow flag |

## Verification
The properties take several things for granted about the inputs:
- `bus_read` and `bus_write` are never high together.
- The router returns no more credits than flits it has received.
- Every response answers a read that is still outstanding.

The bench holds to all three. It drives only one request strobe at a time. Its router model returns exactly one credit per flit it captures, or hands back by hand only credits that were consumed. It sends responses only after the matching reads, including in the overflow scenario.

// File: rtl/noc_adapt_pkg.sv
package noc_adapt_pkg;
  localparam int FLIT_W  = 77;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 31;
  localparam int COORD_W = 4;
  localparam int PID_W   = 2;

  localparam int DATA_LSB = 39;

  typedef logic [FLIT_W-1:0] flit_t;

  localparam logic [1:0] PKT_REQ = 2'b01;
  localparam logic [1:0] PKT_RSP = 2'b10;

  function automatic flit_t pack_request(
    input logic               svc,
    input logic [PID_W-1:0]   pid,
    input logic               is_wr,
    input logic [DATA_W-1:0]  data,
    input logic [ADDR_W-1:0]  addr,
    input logic [COORD_W-1:0] mx,
    input logic [COORD_W-1:0] my
  );
    return {svc, PKT_REQ, pid, is_wr, data, addr, mx, my};
  endfunction

  function automatic logic [DATA_W-1:0] payload_of(input flit_t f);
    return f[DATA_LSB +: DATA_W];
  endfunction
endpackage

// File: rtl/noc_credit_ctr.sv
module noc_credit_ctr #(
  parameter int INIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic give,
  output logic avail
);
  localparam int CW = $clog2(INIT + 1);
  localparam logic [CW-1:0] INIT_V = CW'(INIT);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= INIT_V;
    else if (take && !give) count_q <= count_q - 1'b1;
    else if (give && !take) count_q <= count_q + 1'b1;
  end

  assign avail = (count_q != '0);

  // R4: never exceed the router buffer depth
  a_r4_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= INIT_V);
  // R4: no flit is launched on an empty credit pool
  a_r4_no_take_empty: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> count_q != '0);
endmodule

// File: rtl/noc_req_tx.sv
module noc_req_tx
  import noc_adapt_pkg::*;
#(
  parameter logic               SVC_LEVEL = 1'b0,
  parameter logic [PID_W-1:0]   PROC_ID   = '0,
  parameter logic [COORD_W-1:0] MEM_X     = '0,
  parameter logic [COORD_W-1:0] MEM_Y     = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              is_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              tx_valid,
  output flit_t             tx_flit,
  output logic              wr_pending
);
  logic [DATA_W-1:0] data_field;
  assign data_field = is_wr ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid   <= 1'b0;
      tx_flit    <= '0;
      wr_pending <= 1'b0;
    end else begin
      tx_valid   <= accept;
      wr_pending <= accept && is_wr;
      if (accept)
        tx_flit <= pack_request(SVC_LEVEL, PROC_ID, is_wr, data_field, addr, MEM_X, MEM_Y);
    end
  end

  // R1: every launched flit carries the request type code
  a_r1_req_type: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_flit[75:74] == PKT_REQ);
  // R2: a flit follows every acceptance
  a_r2_one_flit: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> tx_valid);
endmodule

// File: rtl/noc_rsp_fifo.sv
module noc_rsp_fifo
  import noc_adapt_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic              empty,
  output logic [DATA_W-1:0] head,
  output logic              overflow_err
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_V = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_P = PW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0] wr_p, rd_p;
  logic [CW-1:0] count_q;
  logic full, push_ok, pop_ok, drop_evt;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST_P) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count_q == FULL_V);
  assign empty    = (count_q == '0);
  assign push_ok  = push && !full;
  assign drop_evt = push && full;
  assign pop_ok   = pop && !empty;
  assign head     = mem[rd_p];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_p] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_p         <= '0;
      rd_p         <= '0;
      count_q      <= '0;
      overflow_err <= 1'b0;
    end else begin
      if (push_ok) wr_p <= bump(wr_p);
      if (pop_ok)  rd_p <= bump(rd_p);
      count_q <= count_q + CW'(push_ok) - CW'(pop_ok);
      if (drop_evt) overflow_err <= 1'b1;
    end
  end

  // R7: error flag is sticky
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |=> overflow_err);
  // R7: a dropped response raises the flag
  a_r7_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> overflow_err);
  // R7: occupancy never passes the depth
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= FULL_V);
endmodule

// File: rtl/noc_bus_adaptor.sv
module noc_bus_adaptor
  import noc_adapt_pkg::*;
#(
  parameter int                 CREDITS    = 8,
  parameter int                 MAX_OUT    = 16,
  parameter int                 FIFO_DEPTH = 16,
  parameter logic               SVC_LEVEL  = 1'b0,
  parameter logic [PID_W-1:0]   PROC_ID    = '0,
  parameter logic [COORD_W-1:0] MEM_X      = '0,
  parameter logic [COORD_W-1:0] MEM_Y      = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_read,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_waitreq,
  output logic              bus_readvalid,
  output logic [DATA_W-1:0] bus_readdata,
  output logic              tx_valid,
  output logic [FLIT_W-1:0] tx_flit,
  input  logic              credit_ret,
  input  logic              rx_valid,
  input  logic [FLIT_W-1:0] rx_flit,
  output logic              err_overflow
);
  localparam int OW = $clog2(MAX_OUT + 1);
  localparam logic [OW-1:0] OUT_CAP = OW'(MAX_OUT);

  logic cr_avail, wr_pending, accept, rd_accept, pop_evt, fifo_empty;
  logic [DATA_W-1:0] fifo_head;
  logic [OW-1:0] outstanding_q;
  logic at_cap;

  assign at_cap      = (outstanding_q == OUT_CAP);
  assign bus_waitreq = !cr_avail || at_cap || wr_pending;
  assign accept      = (bus_read || bus_write) && !bus_waitreq;
  assign rd_accept   = accept && !bus_write;
  assign pop_evt     = !fifo_empty;

  noc_credit_ctr #(.INIT(CREDITS)) u_credit (
    .clk(clk), .rst_n(rst_n), .take(accept), .give(credit_ret), .avail(cr_avail)
  );

  noc_req_tx #(
    .SVC_LEVEL(SVC_LEVEL), .PROC_ID(PROC_ID), .MEM_X(MEM_X), .MEM_Y(MEM_Y)
  ) u_tx (
    .clk(clk), .rst_n(rst_n), .accept(accept), .is_wr(bus_write),
    .addr(bus_addr), .wdata(bus_wdata), .tx_valid(tx_valid),
    .tx_flit(tx_flit), .wr_pending(wr_pending)
  );

  noc_rsp_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(rx_valid), .push_data(payload_of(rx_flit)),
    .pop(pop_evt), .empty(fifo_empty), .head(fifo_head),
    .overflow_err(err_overflow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding_q <= '0;
      bus_readvalid <= 1'b0;
      bus_readdata  <= '0;
    end else begin
      outstanding_q <= outstanding_q + OW'(rd_accept) - OW'(pop_evt);
      bus_readvalid <= pop_evt;
      if (pop_evt) bus_readdata <= fifo_head;
    end
  end

  // R3: a write blocks the next cycle
  a_r3_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bus_write) |=> bus_waitreq);
  // R5: outstanding reads stay within the cap
  a_r5_out_cap: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding_q <= OUT_CAP);
  // R5: nothing accepted once the cap is reached
  a_r5_cap_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    at_cap |-> !accept);
  // R6: a return always answers an outstanding read
  a_r6_return_owed: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |-> outstanding_q != '0);
  // R6: returned data is the head seen one cycle earlier
  a_r6_data_path: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |=> bus_readvalid && bus_readdata == $past(fifo_head));
endmodule

// File: tb/tb_noc_bus_adaptor.sv
module tb_noc_bus_adaptor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_read = 0, bus_write = 0;
  logic [30:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_waitreq, bus_readvalid, tx_valid, err_overflow;
  logic [31:0] bus_readdata;
  logic [76:0] tx_flit;
  logic rx_valid = 0;
  logic [76:0] rx_flit = '0;
  logic cr_auto = 0, cr_man = 0, auto_en = 1;
  logic credit_ret;
  assign credit_ret = cr_auto | cr_man;

  int checks = 0, errors = 0, cycles = 0;
  int tx_n = 0, rd_n = 0;
  logic [76:0] tx_log [64];
  logic [31:0] rd_log [64];

  always #4 clk = ~clk;

  noc_bus_adaptor #(
    .CREDITS(8), .MAX_OUT(16), .FIFO_DEPTH(1),
    .SVC_LEVEL(1'b1), .PROC_ID(2'd2), .MEM_X(4'd5), .MEM_Y(4'd9)
  ) dut (
    .clk(clk), .rst_n(rst_n), .bus_read(bus_read), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_waitreq(bus_waitreq),
    .bus_readvalid(bus_readvalid), .bus_readdata(bus_readdata),
    .tx_valid(tx_valid), .tx_flit(tx_flit), .credit_ret(credit_ret),
    .rx_valid(rx_valid), .rx_flit(rx_flit), .err_overflow(err_overflow)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    cr_auto <= auto_en && tx_valid;
    if (tx_valid) begin tx_log[tx_n % 64] <= tx_flit; tx_n <= tx_n + 1; end
    if (bus_readvalid) begin rd_log[rd_n % 64] <= bus_readdata; rd_n <= rd_n + 1; end
  end

  function automatic logic [76:0] exp_req(input logic wr, input logic [31:0] d, input logic [30:0] a);
    logic [76:0] f = '0;
    f[3:0] = 4'd9; f[7:4] = 4'd5; f[38:8] = a;
    f[70:39] = wr ? d : 32'h0; f[71] = wr; f[73:72] = 2'd2;
    f[75:74] = 2'b01; f[76] = 1'b1;
    return f;
  endfunction

  function automatic logic [76:0] mk_rsp(input logic [31:0] d);
    logic [76:0] f = '0;
    f[75:74] = 2'b10; f[70:39] = d;
    return f;
  endfunction

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [30:0] a, input logic [31:0] d);
    @(negedge clk);
    while (bus_waitreq) @(negedge clk);
    bus_write = wr; bus_read = !wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_write = 0; bus_read = 0;
  endtask

  task automatic respond(input logic [31:0] d);
    @(negedge clk); rx_valid = 1; rx_flit = mk_rsp(d);
    @(negedge clk); rx_valid = 0;
    @(negedge clk);
    chk("R6", "readvalid pulse", bus_readvalid, 1);
    chk("R6", "readdata", bus_readdata, d);
    @(negedge clk);
    chk("R6", "readvalid single cycle", bus_readvalid, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R8", "waitreq", bus_waitreq, 0);
    chk("R8", "tx_valid", tx_valid, 0);
    chk("R8", "readvalid", bus_readvalid, 0);
    chk("R8", "err", err_overflow, 0);
  endtask

  task automatic t_write;
    @(negedge clk);
    bus_write = 1; bus_addr = 31'h1234_5678; bus_wdata = 32'hCAFE_F00D;
    @(negedge clk);
    chk("R2", "tx_valid after accept", tx_valid, 1);
    chk("R3", "waitreq after write", bus_waitreq, 1);
    bus_write = 0;
    @(negedge clk);
    chk("R2", "tx_valid one cycle", tx_valid, 0);
    chk("R3", "waitreq released", bus_waitreq, 0);
    chk("R1", "write flit", tx_log[(tx_n - 1) % 64], exp_req(1, 32'hCAFE_F00D, 31'h1234_5678));
  endtask

  task automatic t_read_pipe;
    int base = tx_n;
    @(negedge clk); bus_read = 1; bus_addr = 31'h10; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk); chk("R3", "read 2 accepted", bus_waitreq, 0); bus_addr = 31'h20;
    @(negedge clk); chk("R3", "read 3 accepted", bus_waitreq, 0); bus_addr = 31'h7FFF_FFFF;
    @(negedge clk); bus_read = 0;
    @(negedge clk);
    chk("R2", "three flits", tx_n - base, 3);
    chk("R1", "read flit 0", tx_log[base % 64], exp_req(0, 0, 31'h10));
    chk("R1", "read flit 1", tx_log[(base + 1) % 64], exp_req(0, 0, 31'h20));
    chk("R1", "read flit 2", tx_log[(base + 2) % 64], exp_req(0, 0, 31'h7FFF_FFFF));
    respond(32'h1111_0001);
    respond(32'h2222_0002);
    respond(32'h3333_0003);
  endtask

  task automatic t_credit;
    int base;
    auto_en = 0;
    repeat (4) @(negedge clk);
    base = tx_n;
    bus_read = 1; bus_addr = 31'h40;
    repeat (8) @(negedge clk);
    chk("R4", "stall at zero credit", bus_waitreq, 1);
    bus_read = 0;
    repeat (3) @(negedge clk);
    chk("R4", "still stalled", bus_waitreq, 1);
    chk("R4", "flits equal credits", tx_n - base, 8);
    cr_man = 1;
    @(negedge clk); cr_man = 0;
    chk("R4", "credit return releases", bus_waitreq, 0);
    cr_man = 1;
    repeat (7) @(negedge clk);
    cr_man = 0;
    auto_en = 1;
    for (int i = 0; i < 8; i++) respond(32'hA000_0000 + i);
  endtask

  task automatic t_outstanding;
    @(negedge clk); bus_read = 1; bus_addr = 31'h80;
    repeat (16) @(negedge clk);
    chk("R5", "stall at cap", bus_waitreq, 1);
    bus_read = 0;
    repeat (3) @(negedge clk);
    chk("R5", "cap holds", bus_waitreq, 1);
    @(negedge clk); rx_valid = 1; rx_flit = mk_rsp(32'hB000_0000);
    @(negedge clk); rx_valid = 0;
    @(negedge clk);
    chk("R5", "return frees a slot", bus_waitreq, 0);
    chk("R6", "return data", bus_readdata, 32'hB000_0000);
    for (int i = 1; i < 16; i++) respond(32'hB000_0000 + i);
  endtask

  task automatic t_overflow;
    int base;
    issue(0, 31'h100, 0);
    issue(0, 31'h104, 0);
    repeat (3) @(negedge clk);
    base = rd_n;
    @(negedge clk); rx_valid = 1; rx_flit = mk_rsp(32'hD1D1_D1D1);
    @(negedge clk); rx_flit = mk_rsp(32'hD2D2_D2D2);
    @(negedge clk); rx_valid = 0;
    chk("R7", "error raised", err_overflow, 1);
    chk("R7", "first kept", bus_readdata, 32'hD1D1_D1D1);
    @(negedge clk);
    chk("R7", "dropped not returned", bus_readvalid, 0);
    repeat (5) @(negedge clk);
    chk("R7", "error sticky", err_overflow, 1);
    chk("R7", "one return only", rd_n - base, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_write;
    t_read_pipe;
    t_credit;
    t_outstanding;
    t_overflow;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++; errors++;
    $display("FAIL watchdog R2 actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule